// File: doc/BRIEF.md
# Dual Interval Timer Wrapper

This block puts two interval timer channels behind a single 4 KB register window. Byte offsets in the bottom 64 bytes are split between the two channels. The upper half of that range is rebased so that both channels present the same local register layout. The top 32 bytes of the window hold eight read-only identification bytes. The two test registers near the top read as zero. Every other location reads as zero and produces a one-cycle error pulse.

Each channel counts on its own tick-enable input, so the two channels can run at unrelated rates. Each channel drives its own interrupt line, and the wrapper also ORs the two lines into one combined level. Read data is always registered, so every region returns data one clock after the read strobe.

Top module: `dual_timer_wrap`

## Requirements
- R1: A byte offset in 0x000..0x01F reaches channel 0 only, and offset bits [4:2] select the channel register.
- R2: A byte offset in 0x020..0x03F reaches channel 1 only. The wrapper subtracts 0x020 before the access, so 0x020 is channel 1's reload register and writes there leave channel 0 unchanged.
- R3: A read of 0xFE0, 0xFE4, 0xFE8 or 0xFEC returns byte 0, 1, 2 or 3 of the PERIPH_ID parameter, least significant byte first. A read of 0xFF0, 0xFF4, 0xFF8 or 0xFFC returns 0x0D, 0xF0, 0x05 or 0xB1. Bits [31:8] read as zero.
- R4: Writes to 0xFE0..0xFFC have no effect: the identification bytes read back unchanged afterwards, and no error pulse is raised.
- R5: Reads of 0xF00 and 0xF04 return zero, and accesses there raise no error pulse.
- R6: Any access to another offset, or to any offset with bits [1:0] not zero, does three things. A read returns zero. A write is dropped. `bad_access` is high for exactly the one cycle after the access edge.
- R7: `rdata` changes only at the clock edge that samples `rd_en` high, and it shows the addressed data from that edge on. It holds its value while `rd_en` is low.
- R8: `irq_any` is high whenever `irq0` or `irq1` is high, and it is low when both are low. Each channel interrupt leaves on its own output.
- R9: Channel 0 counts only on cycles where `tick_en0` is high, and channel 1 counts only on cycles where `tick_en1` is high.
- R10: The local channel map is as follows.
  - 0x00 is reload. A write there also sets the count.
  - 0x04 is the current count.
  - 0x08 is control: bit7 run, bit6 periodic, bit5 interrupt enable, bits[3:2] prescale (0 for /1, 1 for /16, 2 for /256), bit1 32-bit width, bit0 one-shot. It resets to 0x20.
  - 0x0C clears the interrupt on any write.
  - 0x10 is the raw interrupt and 0x14 is the masked interrupt.
  - 0x18 sets reload without touching the count.

  With control 0xE2 and reload N, the interrupt rises after the N-th counted tick and the count restarts from N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 12 | Byte offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick_en0 | input | 1 | Count enable for channel 0 |
| tick_en1 | input | 1 | Count enable for channel 1 |
| irq0 | output | 1 | Channel 0 interrupt level |
| irq1 | output | 1 | Channel 1 interrupt level |
| irq_any | output | 1 | OR of both channel interrupts |
| bad_access | output | 1 | One-cycle pulse after an access to an unmapped offset |

## Verification
The bench writes different values to 0x000 and 0x020 and to an unmapped offset whose low bits alias 0x000. A decoder that forgot the rebase, or let a stray write fall into a bank, would corrupt the other channel's reload. It reads every identification slot before and after writing to them, so a byte-order slip or a writable identification register shows up as a wrong byte. It runs one channel's ticks while the other's enable is low, then clears the interrupts one at a time. A shared tick or a wrong merge would either move the idle count or drop `irq_any` while one source is still pending. It samples `rdata` just before and just after the read edge, which catches a combinational path or an extra pipeline stage.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int NUM_CH   = 2;
    localparam int ID_BYTES = 8;

    localparam logic [ADDR_W-1:0] CH1_BASE  = 12'h020;
    localparam logic [ADDR_W-1:0] BANK_END  = 12'h040;
    localparam logic [ADDR_W-1:0] TST_CTRL  = 12'hF00;
    localparam logic [ADDR_W-1:0] TST_OUT   = 12'hF04;
    localparam logic [ADDR_W-1:0] ID_BASE   = 12'hFE0;
    localparam logic [31:0]       CELL_WORD = 32'hB105_F00D;

    typedef enum logic [2:0] {
        RG_CH0,
        RG_CH1,
        RG_TEST,
        RG_ID,
        RG_BAD
    } region_e;

    typedef enum logic [2:0] {
        LR_RELOAD  = 3'd0,
        LR_COUNT   = 3'd1,
        LR_CTRL    = 3'd2,
        LR_CLEAR   = 3'd3,
        LR_RAW     = 3'd4,
        LR_MASKED  = 3'd5,
        LR_BGRLD   = 3'd6,
        LR_SPARE   = 3'd7
    } lreg_e;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       rsvd;
        logic [1:0] presc;
        logic       wide;
        logic       single;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{run: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                   rsvd: 1'b0, presc: 2'd0, wide: 1'b0,
                                   single: 1'b0};

    function automatic region_e classify(input logic [ADDR_W-1:0] a);
        region_e r;
        if (a[1:0] != 2'b00)                 r = RG_BAD;
        else if (a < CH1_BASE)               r = RG_CH0;
        else if (a < BANK_END)               r = RG_CH1;
        else if (a == TST_CTRL || a == TST_OUT) r = RG_TEST;
        else if (a >= ID_BASE)               r = RG_ID;
        else                                 r = RG_BAD;
        return r;
    endfunction

    function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] i);
        return w[i*8 +: 8];
    endfunction

endpackage

// File: rtl/dtw_decode.sv
module dtw_decode
    import dtw_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [2:0]        lreg,
    output logic [2:0]        id_idx
);
    logic [ADDR_W-1:0] rebased;
    logic [ADDR_W-1:0] id_off;

    always_comb begin
        region  = classify(addr);
        rebased = (region == RG_CH1) ? (addr - CH1_BASE) : addr;
        id_off  = addr - ID_BASE;
    end

    assign lreg   = rebased[4:2];
    assign id_idx = id_off[4:2];

    logic unused_dec;
    assign unused_dec = ^{rebased[ADDR_W-1:5], rebased[1:0],
                          id_off[ADDR_W-1:5], id_off[1:0]};
endmodule

// File: rtl/dtw_id_rom.sv
module dtw_id_rom
    import dtw_pkg::*;
#(
    parameter logic [31:0] PERIPH_ID = 32'h0014_1804
) (
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);
    logic [7:0] table_q [ID_BYTES];

    for (genvar g = 0; g < ID_BYTES; g++) begin : g_slot
        if (g < 4) begin : g_periph
            assign table_q[g] = byte_of(PERIPH_ID, 2'(g));
        end else begin : g_cell
            assign table_q[g] = byte_of(CELL_WORD, 2'(g - 4));
        end
    end

    assign id_byte = table_q[idx];
endmodule

// File: rtl/dtw_channel.sv
module dtw_channel
    import dtw_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr,
    input  logic [2:0]        lreg,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic              irq
);
    localparam int NARROW_W = 16;
    localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'({NARROW_W{1'b1}});

    logic [CNT_W-1:0] reload_q, count_q;
    ctl_t             ctl_q;
    logic             raw_q;
    logic [7:0]       pre_q;

    logic [CNT_W-1:0] mask, cur;
    logic             fire, at_end;

    always_comb begin
        mask = ctl_q.wide ? '1 : NARROW_MASK;
        cur  = count_q & mask;
        unique case (ctl_q.presc)
            2'd1:    fire = (pre_q[3:0] == 4'hF);
            2'd2:    fire = (pre_q == 8'hFF);
            default: fire = 1'b1;
        endcase
        fire   = fire && tick_en && ctl_q.run;
        at_end = (cur <= CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            count_q  <= '1;
            ctl_q    <= CTL_RESET;
            raw_q    <= 1'b0;
            pre_q    <= '0;
        end else begin
            if (tick_en && ctl_q.run)
                pre_q <= pre_q + 8'd1;
            if (fire) begin
                if (at_end) begin
                    raw_q <= 1'b1;
                    if (ctl_q.single) begin
                        count_q   <= '0;
                        ctl_q.run <= 1'b0;
                    end else if (ctl_q.periodic) begin
                        count_q <= reload_q & mask;
                    end else begin
                        count_q <= mask;
                    end
                end else begin
                    count_q <= cur - CNT_W'(1);
                end
            end
            if (wr) begin
                unique case (lreg_e'(lreg))
                    LR_RELOAD: begin
                        reload_q <= wdata[CNT_W-1:0];
                        count_q  <= wdata[CNT_W-1:0] & mask;
                    end
                    LR_CTRL: begin
                        ctl_q      <= ctl_t'(wdata[7:0]);
                        ctl_q.rsvd <= 1'b0;
                        pre_q      <= '0;
                    end
                    LR_CLEAR:  if (!(fire && at_end)) raw_q <= 1'b0;
                    LR_BGRLD:  reload_q <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (lreg_e'(lreg))
            LR_RELOAD, LR_BGRLD: rd_word[CNT_W-1:0] = reload_q;
            LR_COUNT:            rd_word[CNT_W-1:0] = cur;
            LR_CTRL:             rd_word[7:0] = ctl_q;
            LR_RAW:              rd_word[0] = raw_q;
            LR_MASKED:           rd_word[0] = raw_q & ctl_q.irq_en;
            default: ;
        endcase
    end

    assign irq = raw_q & ctl_q.irq_en;

    logic unused_ch;
    assign unused_ch = ^wdata[DATA_W-1:CNT_W] ^ ^wdata;
endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
    import dtw_pkg::*;
#(
    parameter logic [31:0] PERIPH_ID = 32'h0014_1804
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              tick_en0,
    input  logic              tick_en1,
    output logic              irq0,
    output logic              irq1,
    output logic              irq_any,
    output logic              bad_access
);
    region_e          region;
    logic [2:0]       lreg, id_idx;
    logic [7:0]       id_byte;
    logic [NUM_CH-1:0] ticks, ch_irq, ch_wr;
    logic [DATA_W-1:0] ch_rd [NUM_CH];
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;
    logic              bad_q;

    dtw_decode u_dec (
        .addr   (addr),
        .region (region),
        .lreg   (lreg),
        .id_idx (id_idx)
    );

    dtw_id_rom #(.PERIPH_ID(PERIPH_ID)) u_id (
        .idx     (id_idx),
        .id_byte (id_byte)
    );

    assign ticks = {tick_en1, tick_en0};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam region_e MY_RG = (c == 0) ? RG_CH0 : RG_CH1;
        assign ch_wr[c] = wr_en && (region == MY_RG);
        dtw_channel #(.CNT_W(DATA_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick_en (ticks[c]),
            .wr      (ch_wr[c]),
            .lreg    (lreg),
            .wdata   (wdata),
            .rd_word (ch_rd[c]),
            .irq     (ch_irq[c])
        );
    end

    always_comb begin
        unique case (region)
            RG_CH0:  rd_next = ch_rd[0];
            RG_CH1:  rd_next = ch_rd[1];
            RG_ID:   rd_next = {24'h0, id_byte};
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            bad_q   <= 1'b0;
        end else begin
            if (rd_en)
                rdata_q <= rd_next;
            bad_q <= (rd_en || wr_en) && (region == RG_BAD);
        end
    end

    assign rdata      = rdata_q;
    assign bad_access = bad_q;
    assign irq0       = ch_irq[0];
    assign irq1       = ch_irq[1];
    assign irq_any    = |ch_irq;
endmodule

// File: rtl/dtw_checker.sv
module dtw_checker (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        wr_en,
    input logic [11:0] addr,
    input logic [31:0] rdata,
    input logic        irq0,
    input logic        irq1,
    input logic        irq_any,
    input logic        bad_access
);
    logic addr_unmapped;
    assign addr_unmapped = (addr[1:0] != 2'b00) ||
                           (addr >= 12'h040 && addr < 12'hFE0 &&
                            addr != 12'hF00 && addr != 12'hF04);

    function automatic logic [7:0] cell_at(input logic [1:0] k);
        case (k)
            2'd0:    return 8'h0D;
            2'd1:    return 8'hF0;
            2'd2:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    AST_BAD_SOURCE: assert property (@(posedge clk) disable iff (rst)
        bad_access |-> $past((rd_en || wr_en) && addr_unmapped)) else $error("bad src"); // R6

    AST_TEST_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == 12'hF00 || addr == 12'hF04)) |=> (rdata == 32'h0 && !bad_access)) else $error("test"); // R5

    AST_CELL_ID: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[11:4] == 8'hFF && addr[1:0] == 2'b00)
        |=> (rdata == {24'h0, cell_at($past(addr[3:2]))})) else $error("cell"); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)) else $error("hold"); // R7

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_any) |-> ($rose(irq0) || $rose(irq1))) else $error("merge"); // R8
endmodule

bind dual_timer_wrap dtw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .rdata      (rdata),
    .irq0       (irq0),
    .irq1       (irq1),
    .irq_any    (irq_any),
    .bad_access (bad_access)
);

// File: tb/tb_dual_timer_wrap.sv
`timescale 1ns/1ps
module tb_dual_timer_wrap;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_en0 = 1'b0, tick_en1 = 1'b0;
    logic        irq0, irq1, irq_any, bad_access;

    int checks = 0;
    int errors = 0;
    logic [31:0] pid = 32'h0014_1804;

    always #2 clk = ~clk;

    dual_timer_wrap dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_en0(tick_en0), .tick_en1(tick_en1),
        .irq0(irq0), .irq1(irq1), .irq_any(irq_any), .bad_access(bad_access)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output logic bad);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1; bad = bad_access;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic bad);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(posedge clk); #1; d = rdata; bad = bad_access;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tick(input int ch, input int n);
        @(negedge clk);
        if (ch == 0) tick_en0 = 1'b1; else tick_en1 = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk); tick_en0 = 1'b0; tick_en1 = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic b;
        check("R10 reset rdata", rdata, 32'h0);
        check("R8 reset irqs", {29'h0, irq0, irq1, irq_any}, 32'h0);
        check("R6 reset bad", {31'h0, bad_access}, 32'h0);
        bus_read(12'h008, d, b); check("R10 ch0 control reset", d, 32'h20);
        bus_read(12'h028, d, b); check("R2 ch1 control reset", d, 32'h20);
    endtask

    task automatic t_banks;
        logic [31:0] d; logic b;
        bus_write(12'h000, 32'h1234, b);
        bus_write(12'h020, 32'h5678, b);
        bus_read(12'h000, d, b); check("R1 ch0 reload", d, 32'h1234);
        bus_read(12'h020, d, b); check("R2 ch1 reload rebased", d, 32'h5678);
        bus_read(12'h024, d, b); check("R2 ch1 count", d, 32'h5678);
        bus_write(12'h018, 32'h00AB, b);
        bus_read(12'h000, d, b); check("R1 ch0 bg reload", d, 32'h00AB);
        bus_read(12'h004, d, b); check("R1 ch0 count kept", d, 32'h1234);
        bus_write(12'h000, 32'h1234, b);
    endtask

    task automatic t_id;
        logic [31:0] d; logic b;
        logic [31:0] cellw = 32'hB105_F00D;
        for (int i = 0; i < 4; i++) begin
            bus_read(12'hFE0 + 12'(4*i), d, b);
            check($sformatf("R3 periph byte %0d", i), d, {24'h0, pid[8*i +: 8]});
            bus_read(12'hFF0 + 12'(4*i), d, b);
            check($sformatf("R3 cell byte %0d", i), d, {24'h0, cellw[8*i +: 8]});
        end
        bus_write(12'hFE0, 32'hFFFF_FFFF, b);
        check("R4 id write no error", {31'h0, b}, 32'h0);
        bus_write(12'hFFC, 32'h0, b);
        bus_read(12'hFE0, d, b); check("R4 periph unchanged", d, {24'h0, pid[7:0]});
        bus_read(12'hFFC, d, b); check("R4 cell unchanged", d, 32'hB1);
    endtask

    task automatic t_test_regs;
        logic [31:0] d; logic b;
        bus_read(12'hF00, d, b); check("R5 test ctrl zero", d, 32'h0);
        check("R5 test ctrl no error", {31'h0, b}, 32'h0);
        bus_write(12'hF04, 32'h1, b);
        check("R5 test out write no error", {31'h0, b}, 32'h0);
        bus_read(12'hF04, d, b); check("R5 test out zero", d, 32'h0);
    endtask

    task automatic t_bad;
        logic [31:0] d; logic b;
        bus_write(12'h100, 32'hDEAD, b);
        check("R6 write pulse", {31'h0, b}, 32'h1);
        @(posedge clk); #1;
        check("R6 pulse one cycle", {31'h0, bad_access}, 32'h0);
        bus_read(12'h100, d, b);
        check("R6 read zero", d, 32'h0);
        check("R6 read pulse", {31'h0, b}, 32'h1);
        bus_write(12'h002, 32'hBEEF, b);
        check("R6 misaligned pulse", {31'h0, b}, 32'h1);
        bus_read(12'h000, d, b); check("R6 write dropped", d, 32'h1234);
        check("R6 good read no pulse", {31'h0, b}, 32'h0);
    endtask

    task automatic t_latency;
        logic [31:0] d; logic b;
        bus_read(12'h000, d, b);
        @(negedge clk); rd_en = 1'b1; addr = 12'h020;
        #1; check("R7 old value before edge", rdata, 32'h1234);
        @(posedge clk); #1; check("R7 new value after edge", rdata, 32'h5678);
        @(negedge clk); rd_en = 1'b0; addr = 12'h000;
        repeat (2) @(posedge clk); #1;
        check("R7 held while idle", rdata, 32'h5678);
    endtask

    task automatic t_irq;
        logic [31:0] d; logic b;
        bus_write(12'h000, 32'd3, b);
        bus_write(12'h008, 32'hE2, b);
        bus_write(12'h020, 32'd2, b);
        bus_write(12'h028, 32'hE2, b);
        tick(0, 2);
        check("R10 no irq before Nth tick", {31'h0, irq0}, 32'h0);
        bus_read(12'h004, d, b); check("R10 count after 2", d, 32'd1);
        tick(0, 1);
        check("R10 irq0 at Nth tick", {31'h0, irq0}, 32'h1);
        check("R8 irq_any from ch0", {30'h0, irq_any, irq1}, 32'h2);
        bus_read(12'h004, d, b); check("R10 count reloaded", d, 32'd3);
        bus_read(12'h014, d, b); check("R10 masked status", d, 32'h1);
        bus_read(12'h024, d, b); check("R9 ch1 idle count", d, 32'd2);
        tick(1, 2);
        check("R9 irq1 on own ticks", {31'h0, irq1}, 32'h1);
        bus_write(12'h00C, 32'h0, b);
        check("R8 irq0 cleared", {31'h0, irq0}, 32'h0);
        check("R8 irq_any held by ch1", {31'h0, irq_any}, 32'h1);
        bus_write(12'h02C, 32'h0, b);
        check("R8 irq_any low", {31'h0, irq_any}, 32'h0);
        bus_write(12'h008, 32'h00, b);
        bus_write(12'h028, 32'h00, b);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        t_reset();
        t_banks();
        t_id();
        t_test_regs();
        t_bad();
        t_latency();
        t_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule